// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers level-sensitive interrupt requests from three 8-bit groups: two local groups and one mappable group. Each local group has a read-only status view and a writable enable mask. The mappable group has one status view and two enable masks. Each mask selects a sub-group of the mappable sources. The OR of each masked sub-group is folded into one fixed status bit of a local group. The processor therefore sees only two combined request lines, one per local group. Both lines are registered.

The block also latches two timer events. Software drops each latched event by writing a 1 to its bit in a write-only clear register. All registers sit on a plain byte-wide port: an address, a write strobe, write data, and read data that is always driven from the current address. A driver starts with every mask at zero. It then enables sources one at a time by read-modify-write of a mask.

Top module: `cic_top`

## Requirements
- R1: After reset, all four mask registers read 0, both timer latches are 0 and both `irq_out` bits are 0.
- R2: A write with `reg_wr`=1 to a mask address loads `reg_wdata` on that clock edge. The new value reads back from the next cycle on. The mask addresses are 0x1 (local 0), 0x3 (local 1), 0x5 (mappable mask 0) and 0x9 (mappable mask 1).
- R3: The local 0 status reads at 0x0. A source is pending when its status bit and its mask bit are both 1. `irq_out[0]` equals the OR of the pending bits, one clock after the inputs and mask that produce it.
- R4: The local 1 status reads at 0x2 and carries sources 8 to 15. `irq_out[1]` is the OR of (local 1 status AND local 1 mask), one clock later.
- R5: The mappable status reads at 0x4 and shows `map_req`. Bit 7 of the local 0 status is `loc0_req[7]` ORed with the OR of (`map_req` AND mappable mask 0).
- R6: Bit 3 of the local 1 status is `loc1_req[3]` ORed with the OR of (`map_req` AND mappable mask 1).
- R7: Mappable mask 1 is at the address of mappable mask 0 plus 4, which is 0x9.
- R8: A 1 on `tmr_evt[i]` sets timer latch i on the next edge, and the latch shows on `timer_irq[i]`. A write to 0x6 clears latch 0 when data bit 0 is 1 and latch 1 when data bit 1 is 1; the value 0x03 clears both. An event in the same cycle as its clear leaves the latch set.
- R9: Writes to the status addresses 0x0, 0x2 and 0x4, and to unmapped addresses, change no mask and no output. Unmapped addresses read 0.
- R10: The clear register at 0x6 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| loc0_req | input | 8 | Level requests, local group 0 (sources 0-7) |
| loc1_req | input | 8 | Level requests, local group 1 (sources 8-15) |
| map_req | input | 8 | Level requests, mappable group |
| tmr_evt | input | 2 | Timer event pulses to latch |
| irq_out | output | 2 | Registered combined requests of local groups 0 and 1 |
| timer_irq | output | 2 | Latched timer requests |

## Verification
A wrong mask bit shows within one cycle on the register read port, and on `irq_out` one clock after a matching request is driven. A wrong cascade bit shows at once in the local status read, and on the combined line one clock later. A stuck or missed timer latch shows on `timer_irq` in the cycle after the event or the clear. Because the bench compares every output on every clock, any divergence is reported in the cycle it first appears.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ADDR_W = 4;
  localparam int TMR_N  = 2;
  localparam int N_MASK = 4;

  localparam logic [ADDR_W-1:0] A_L0_STAT = 4'h0;
  localparam logic [ADDR_W-1:0] A_L0_MASK = 4'h1;
  localparam logic [ADDR_W-1:0] A_L1_STAT = 4'h2;
  localparam logic [ADDR_W-1:0] A_L1_MASK = 4'h3;
  localparam logic [ADDR_W-1:0] A_MP_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_MP_MSK0 = 4'h5;
  localparam logic [ADDR_W-1:0] A_TMR_CLR = 4'h6;
  // the second mappable mask sits four above the first
  localparam logic [ADDR_W-1:0] A_MP_MSK1 = A_MP_MSK0 + 4'h4;

  // mask slot order: 0 local0, 1 local1, 2 mappable0, 3 mappable1
  function automatic logic [ADDR_W-1:0] mask_addr(input int idx);
    case (idx)
      0:       return A_L0_MASK;
      1:       return A_L1_MASK;
      2:       return A_MP_MSK0;
      default: return A_MP_MSK1;
    endcase
  endfunction
endpackage

// File: rtl/cic_regs.sv
module cic_regs import cic_pkg::*; #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [W-1:0]        wdata,
  input  logic [TMR_N-1:0]    tmr_evt,
  output logic [N_MASK*W-1:0] masks,
  output logic [TMR_N-1:0]    tmr_lat
);
  logic [TMR_N-1:0] clr;

  for (genvar i = 0; i < N_MASK; i++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               masks[i*W +: W] <= '0;
      else if (wr && addr == mask_addr(i))      masks[i*W +: W] <= wdata;
    end
  end

  always_comb clr = (wr && addr == A_TMR_CLR) ? wdata[TMR_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_lat <= '0;
    else        tmr_lat <= (tmr_lat & ~clr) | tmr_evt;
  end

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(masks));
  p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt[0] |=> tmr_lat[0]);
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_TMR_CLR && wdata[0] && !tmr_evt[0]) |=> !tmr_lat[0]);
  p_clear_drops1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_TMR_CLR && wdata[1] && !tmr_evt[1]) |=> !tmr_lat[1]);
endmodule

// File: rtl/cic_group.sv
module cic_group #(
  parameter int W        = 8,
  parameter int CASC_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         casc,
  input  logic [W-1:0] msk,
  output logic [W-1:0] stat,
  output logic         irq_q
);
  always_comb begin
    stat           = req;
    stat[CASC_BIT] = req[CASC_BIT] | casc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat & msk);
  end

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |=> !irq_q);
  // cascade visible in status: R5 for group 0, R6 for group 1
  p_cascade_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    casc |-> stat[CASC_BIT]);
endmodule

// File: rtl/cic_top.sv
module cic_top import cic_pkg::*; #(
  parameter int W         = 8,
  parameter int CASC0_BIT = 7,
  parameter int CASC1_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      loc0_req,
  input  logic [W-1:0]      loc1_req,
  input  logic [W-1:0]      map_req,
  input  logic [TMR_N-1:0]  tmr_evt,
  output logic [1:0]        irq_out,
  output logic [TMR_N-1:0]  timer_irq
);
  localparam int N_GRP = 2;

  logic [N_MASK*W-1:0]    masks;
  logic [W-1:0]           m_l0, m_l1, m_mp0, m_mp1;
  logic [N_GRP-1:0][W-1:0] g_req, g_msk, g_stat;
  logic [N_GRP-1:0]       g_casc;

  cic_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .tmr_evt(tmr_evt), .masks(masks), .tmr_lat(timer_irq)
  );

  always_comb begin
    m_l0  = masks[0*W +: W];
    m_l1  = masks[1*W +: W];
    m_mp0 = masks[2*W +: W];
    m_mp1 = masks[3*W +: W];
    g_req[0]  = loc0_req;
    g_req[1]  = loc1_req;
    g_msk[0]  = m_l0;
    g_msk[1]  = m_l1;
    g_casc[0] = |(map_req & m_mp0);
    g_casc[1] = |(map_req & m_mp1);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int CB = (g == 0) ? CASC0_BIT : CASC1_BIT;
    cic_group #(.W(W), .CASC_BIT(CB)) u_grp (
      .clk(clk), .rst_n(rst_n), .req(g_req[g]), .casc(g_casc[g]),
      .msk(g_msk[g]), .stat(g_stat[g]), .irq_q(irq_out[g])
    );
  end

  always_comb begin
    case (reg_addr)
      A_L0_STAT: reg_rdata = g_stat[0];
      A_L0_MASK: reg_rdata = m_l0;
      A_L1_STAT: reg_rdata = g_stat[1];
      A_L1_MASK: reg_rdata = m_l1;
      A_MP_STAT: reg_rdata = map_req;
      A_MP_MSK0: reg_rdata = m_mp0;
      A_MP_MSK1: reg_rdata = m_mp1;
      default:   reg_rdata = '0;
    endcase
  end

  p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_L0_STAT || reg_addr == A_L1_STAT ||
                reg_addr == A_MP_STAT)) |=> $stable(masks));
  p_mask1_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MP_MSK0 + 4'h4) |=> (m_mp1 == $past(reg_wdata)));
endmodule

// File: tb/tb_cic_top.sv
`timescale 1ns/1ps
module tb_cic_top;
  logic       clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, loc0_req = 0, loc1_req = 0, map_req = 0;
  logic [1:0] tmr_evt = 0, irq_out, timer_irq;

  cic_top dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";
  logic [7:0] mm [4];
  logic [1:0] mt, mi;

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    logic [7:0] s;
    case (a)
      4'h0: begin s = loc0_req; if ((map_req & mm[2]) != 0) s[7] = 1; return s; end
      4'h1: return mm[0];
      4'h2: begin s = loc1_req; if ((map_req & mm[3]) != 0) s[3] = 1; return s; end
      4'h3: return mm[1];
      4'h4: return map_req;
      4'h5: return mm[2];
      4'h9: return mm[3];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [1:0] ni, nt, clr;
    logic [7:0] s0, s1;
    @(posedge clk);
    if (!rst_n) begin
      foreach (mm[k]) mm[k] = 0; mt = 0; mi = 0;
    end else begin
      s0 = exp_read(4'h0); s1 = exp_read(4'h2);
      ni = {((s1 & mm[1]) != 0), ((s0 & mm[0]) != 0)};
      clr = (reg_wr && reg_addr == 4'h6) ? reg_wdata[1:0] : 2'b00;
      nt = (mt & ~clr) | tmr_evt;
      if (reg_wr) case (reg_addr)
        4'h1: mm[0] = reg_wdata;
        4'h3: mm[1] = reg_wdata;
        4'h5: mm[2] = reg_wdata;
        4'h9: mm[3] = reg_wdata;
        default: ;
      endcase
      mi = ni; mt = nt;
    end
    #1;
    chk("irq_out", {6'b0, irq_out}, {6'b0, mi});
    chk("timer_irq", {6'b0, timer_irq}, {6'b0, mt});
    chk("reg_rdata", reg_rdata, exp_read(reg_addr));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a; tick();
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mm[k]) mm[k] = 0; mt = 0; mi = 0;
    repeat (2) tick();
    rst_n = 1;
    // R1: reset state, masks zero, requests active yet no irq
    phase = "R1";
    loc0_req = 8'hFF; loc1_req = 8'hFF; map_req = 8'hFF;
    rd(4'h1); rd(4'h3); rd(4'h5); rd(4'h9); rd(4'h0); rd(4'h2);
    loc0_req = 0; loc1_req = 0; map_req = 0;
    // R2: mask write and readback
    phase = "R2";
    wr(4'h1, 8'hA5); rd(4'h1); wr(4'h3, 8'h3C); rd(4'h3);
    wr(4'h5, 8'h0F); rd(4'h5);
    wr(4'h1, 8'h00); wr(4'h3, 8'h00); wr(4'h5, 8'h00);
    // R3: local 0 pending and registered output
    phase = "R3";
    wr(4'h1, 8'h0F);
    reg_addr = 4'h0;
    loc0_req = 8'h10; tick(); tick();
    loc0_req = 8'h01; tick(); tick();
    loc0_req = 8'h08; tick();
    loc0_req = 8'h00; tick(); tick();
    // R4: local 1
    phase = "R4";
    wr(4'h3, 8'hC0); reg_addr = 4'h2;
    loc1_req = 8'h40; tick(); tick();
    loc1_req = 8'h3F; tick(); tick();
    loc1_req = 8'h00; tick();
    // R5: mappable mask 0 cascade into local 0 bit 7
    phase = "R5";
    wr(4'h1, 8'h80); wr(4'h5, 8'h22);
    reg_addr = 4'h4; map_req = 8'h04; tick(); tick();
    reg_addr = 4'h0; map_req = 8'h20; tick(); tick();
    map_req = 8'h00; tick(); tick();
    // R7: second mappable mask at base + 4
    phase = "R7";
    wr(4'h9, 8'h81); rd(4'h9); rd(4'h5);
    // R6: mappable mask 1 cascade into local 1 bit 3
    phase = "R6";
    wr(4'h3, 8'h08); reg_addr = 4'h2;
    map_req = 8'h80; tick(); tick();
    map_req = 8'h02; tick(); tick();
    map_req = 8'h00; tick(); tick();
    // R8: timer latches and clear
    phase = "R8";
    tmr_evt = 2'b11; tick(); tmr_evt = 0; tick();
    wr(4'h6, 8'h01); tick();
    wr(4'h6, 8'h02); tick();
    tmr_evt = 2'b11; tick(); tmr_evt = 0;
    wr(4'h6, 8'h03); tick();
    tmr_evt = 2'b01; tick(); tmr_evt = 2'b01;
    wr(4'h6, 8'h03); tmr_evt = 0; tick();
    // R10: clear register reads zero
    phase = "R10";
    rd(4'h6);
    // R9: status writes ignored, unmapped reads zero
    phase = "R9";
    loc0_req = 8'h80;
    wr(4'h0, 8'hFF); wr(4'h2, 8'hFF); wr(4'h4, 8'hFF); wr(4'hF, 8'hFF);
    rd(4'h1); rd(4'h3); rd(4'h5); rd(4'h9); rd(4'hF); rd(4'h7);
    loc0_req = 0; tick(); tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule